// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block gathers level-sensitive interrupt requests from a number of devices and merges them onto a smaller set of shared interrupt lines. Every device drives four request pins. A mapping function routes each pin to one shared line. That function depends on the device index and the pin index, and a parameter selects one of three variants.

The block does not OR the pins together. It keeps a count of asserted sources for each shared line, and a line is high while its count is nonzero. The block also remembers the last level seen on every pin. It acts only when a level changes: a rise adds one to the count of the mapped line, and a fall subtracts one. Several changes in the same cycle are all applied in that cycle.

A per-device attach strobe brings that device back to a clean state. All its stored levels are cleared, and any contribution it was making to the shared lines is removed.

Top module: `irq_share_aggr`

## Requirements
- R1: While rst_ni is low, and after it is released with no pin change, every bit of line_o is 0 and every stored pin level is 0.
- R2: When a stored-low pin is sampled high at a rising clock edge, the count of its mapped line goes up by one, and the line bit is 1 after that same edge.
- R3: When a stored-high pin is sampled low, the count of its mapped line goes down by one. The line stays 1 while another pin mapped to it is still high, and goes to 0 after the edge that removes the last one.
- R4: A bit of line_o is 1 exactly when the number of stored-high pins mapped to that line is nonzero.
- R5: A pin held at its stored level for any number of cycles adds nothing further. One fall after a long high period drops the line when no other source is mapped to it.
- R6: All pin changes sampled at the same edge, on any devices and lines, are applied to the counts at that edge.
- R7: With the default mapping mode, pin p of device d (pin bit index d*4+p of dev_pin_i) drives line (d+p) mod NUM_LINES. Two other mode values route by p mod NUM_LINES and by d mod NUM_LINES.
- R8: When dev_attach_i[d] is sampled high, the four stored levels of device d are cleared and their contribution is removed from the counts. That device's pin inputs are ignored for that edge, so a pin still high is counted again as a rise at the next edge.
- R9: The count of each line can hold the total number of device pins and never goes below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_pin_i | input | NUM_DEV*4 | Pin levels; bit d*4+p is pin p of device d |
| dev_attach_i | input | NUM_DEV | Per-device attach strobe that clears that device's stored state |
| line_o | output | NUM_LINES | Shared interrupt line levels |

## Verification
Every result of this block is due one rising edge after the stimulus. A pin change or an attach strobe sampled at edge N changes the stored levels, the counts and line_o just after edge N. The bench drives inputs on the falling edge and reads line_o on the next falling edge, after exactly one rising edge. A behavioural model of the stored levels and counts is updated at the same rising edge from the same inputs, and it is compared with line_o at each falling edge. The directed cases also compare against hand-computed line patterns at that same sampling point.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

  localparam int unsigned PINS_PER_DEV = 4;

  typedef enum logic [1:0] {
    MAP_ROTATE = 2'd0,
    MAP_BY_PIN = 2'd1,
    MAP_BY_DEV = 2'd2
  } map_mode_e;

  function automatic int unsigned route_line(int unsigned dev, int unsigned pin,
                                             int unsigned lines, map_mode_e mode);
    case (mode)
      MAP_BY_PIN: return pin % lines;
      MAP_BY_DEV: return dev % lines;
      default:    return (dev + pin) % lines;
    endcase
  endfunction

endpackage

// File: rtl/irq_pin_track.sv
module irq_pin_track
  import irq_aggr_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PINS_PER_DEV-1:0] pin_i,
  input  logic                    attach_i,
  output logic [PINS_PER_DEV-1:0] rise_o,
  output logic [PINS_PER_DEV-1:0] fall_o,
  output logic [PINS_PER_DEV-1:0] level_o
);

  logic [PINS_PER_DEV-1:0] level_q, level_d;

  always_comb begin
    if (attach_i) begin
      rise_o  = '0;
      fall_o  = level_q;
      level_d = '0;
    end else begin
      rise_o  = pin_i & ~level_q;
      fall_o  = ~pin_i & level_q;
      level_d = pin_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= level_d;
  end

  assign level_o = level_q;

  assert_attach_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attach_i |=> (level_o == '0));

  // a pin held steady since the last edge raises no event
  assert_steady_no_event_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !attach_i && !$past(attach_i) && $stable(pin_i))
      |-> ((rise_o | fall_o) == '0));

endmodule

// File: rtl/irq_line_count.sv
module irq_line_count #(
  parameter int unsigned NUM_SRC = 16,
  localparam int unsigned CW     = $clog2(NUM_SRC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] inc_i,
  input  logic [NUM_SRC-1:0] dec_i,
  output logic               line_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] n_inc, n_dec;
  logic [CW:0]   sum;

  always_comb begin
    n_inc = '0;
    n_dec = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      n_inc = n_inc + CW'(inc_i[s]);
      n_dec = n_dec + CW'(dec_i[s]);
    end
    sum = {1'b0, cnt_q} + {1'b0, n_inc};
    // floor at zero instead of wrapping
    if (sum < {1'b0, n_dec}) cnt_d = '0;
    else                     cnt_d = CW'(sum - {1'b0, n_dec});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign line_o = (cnt_q != '0);

  assert_count_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NUM_SRC));

  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && n_inc == '0) |=> (cnt_q == '0));

  assert_rise_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_inc > n_dec) |=> line_o);

  assert_last_fall_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_inc == '0 && n_dec != '0 && cnt_q == n_dec) |=> !line_o);

endmodule

// File: rtl/irq_share_aggr.sv
module irq_share_aggr
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_DEV   = 4,
  parameter int unsigned NUM_LINES = 4,
  parameter map_mode_e   MAP_MODE  = MAP_ROTATE,
  localparam int unsigned NUM_SRC  = NUM_DEV * PINS_PER_DEV
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   dev_pin_i,
  input  logic [NUM_DEV-1:0]   dev_attach_i,
  output logic [NUM_LINES-1:0] line_o
);

  logic [NUM_SRC-1:0] rise, fall, level;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    irq_pin_track u_track (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (dev_pin_i[d*PINS_PER_DEV +: PINS_PER_DEV]),
      .attach_i (dev_attach_i[d]),
      .rise_o   (rise[d*PINS_PER_DEV +: PINS_PER_DEV]),
      .fall_o   (fall[d*PINS_PER_DEV +: PINS_PER_DEV]),
      .level_o  (level[d*PINS_PER_DEV +: PINS_PER_DEV])
    );
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [NUM_SRC-1:0] inc_vec, dec_vec, lvl_vec;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam int unsigned ROUTE =
        route_line(s / PINS_PER_DEV, s % PINS_PER_DEV, NUM_LINES, MAP_MODE);
      localparam bit HIT = (ROUTE == l);
      assign inc_vec[s] = rise[s]  & HIT;
      assign dec_vec[s] = fall[s]  & HIT;
      assign lvl_vec[s] = level[s] & HIT;
    end

    irq_line_count #(.NUM_SRC(NUM_SRC)) u_count (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc_vec),
      .dec_i  (dec_vec),
      .line_o (line_o[l])
    );

    assert_quiet_line_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_vec == '0) |-> !line_o[l]);

    assert_busy_line_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_vec != '0) |-> line_o[l]);
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (line_o == '0 && level == '0));

endmodule

// File: tb/irq_share_aggr_tb_top.sv
`timescale 1ns/1ps
module irq_share_aggr_tb_top;

  localparam int ND = 4;
  localparam int NL = 4;
  localparam int NS = ND * 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] pins = '0;
  logic [ND-1:0] attach = '0;
  logic [NL-1:0] line_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int m_lvl [NS];
  int m_cnt [NL];

  always #2.5 clk_i = ~clk_i;

  irq_share_aggr #(.NUM_DEV(ND), .NUM_LINES(NL)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dev_pin_i    (pins),
    .dev_attach_i (attach),
    .line_o       (line_o)
  );

  function automatic int map_of(int s);
    return ((s / 4) + (s % 4)) % NL;   // R7 default rotation
  endfunction

  // behavioural model
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NS; s++) m_lvl[s] = 0;
      for (int l = 0; l < NL; l++) m_cnt[l] = 0;
    end else begin
      for (int s = 0; s < NS; s++) begin
        if (attach[s/4]) begin
          if (m_lvl[s] == 1) m_cnt[map_of(s)]--;
          m_lvl[s] = 0;
        end else if (int'(pins[s]) != m_lvl[s]) begin
          if (pins[s]) m_cnt[map_of(s)]++;
          else         m_cnt[map_of(s)]--;
          m_lvl[s] = int'(pins[s]);
        end
      end
    end
  end

  function automatic logic [NL-1:0] model_lines();
    logic [NL-1:0] v;
    for (int l = 0; l < NL; l++) v[l] = (m_cnt[l] != 0);
    return v;
  endfunction

  // per-cycle comparison against the model (R4, R9)
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      n_tests++;
      if (line_o !== model_lines()) begin
        n_fail++;
        $display("FAIL R4/R9 model compare t=%0t actual=%b expected=%b", $time, line_o, model_lines());
      end
    end
  end

  task automatic chk(string tag, logic [NL-1:0] exp);
    n_tests++;
    if (line_o !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, line_o, exp);
    end
  endtask

  task automatic apply(logic [NS-1:0] p, logic [ND-1:0] a);
    pins   = p;
    attach = a;
    @(negedge clk_i);
  endtask

  function automatic logic [NS-1:0] bit_of(int d, int p);
    logic [NS-1:0] v = '0;
    v[d*4+p] = 1'b1;
    return v;
  endfunction

  initial begin
    pins = '0; attach = '0;
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", 4'b0000);
    rst_ni = 1'b1;
    apply('0, '0);
    chk("R1 after release", 4'b0000);

    apply(bit_of(0,1), '0);
    chk("R2 single rise", 4'b0010);
    apply('0, '0);

    apply(bit_of(3,3), '0);
    chk("R7 dev3 pin3 to line2", 4'b0100);
    apply(bit_of(2,3), '0);
    chk("R7 dev2 pin3 to line1", 4'b0010);
    apply('0, '0);

    apply(bit_of(0,0) | bit_of(1,3), '0);
    chk("R3 two on line0", 4'b0001);
    apply(bit_of(1,3), '0);
    chk("R3 one fall keeps line", 4'b0001);
    apply('0, '0);
    chk("R3 last fall clears", 4'b0000);

    apply(bit_of(2,1), '0);
    repeat (5) apply(bit_of(2,1), '0);
    chk("R5 held high", 4'b1000);
    apply('0, '0);
    chk("R5 single fall clears", 4'b0000);

    apply(bit_of(0,0) | bit_of(1,3) | bit_of(2,2) | bit_of(0,1), '0);
    chk("R6 simultaneous rises", 4'b0011);
    apply(bit_of(2,2), '0);
    chk("R6 simultaneous falls", 4'b0001);
    apply('0, '0);
    chk("R6 all low", 4'b0000);

    apply(bit_of(1,0), '0);
    chk("R8 before attach", 4'b0010);
    apply(bit_of(1,0), 4'b0010);
    chk("R8 attach clears", 4'b0000);
    apply(bit_of(1,0), '0);
    chk("R8 recount after attach", 4'b0010);
    apply('0, 4'b0010);
    chk("R8 attach on low pin", 4'b0000);
    apply('0, '0);
    chk("R9 no underflow", 4'b0000);

    for (int i = 0; i < 4000; i++) begin
      logic [NS-1:0] p;
      logic [ND-1:0] a;
      p = NS'($urandom);
      a = (($urandom % 8) == 0) ? ND'($urandom) : '0;
      apply(p, a);
    end
    apply('0, '0);
    chk("R9 drained", 4'b0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule